// File: doc/BRIEF.md
# Register Integrity and Access Monitor

This block holds a small file of host-visible configuration words and a window of data-memory words, and watches them for tampering. A checksum engine walks every covered word once per scan and builds a CRC-16 (polynomial 0x1021, seed 0xFFFF, most significant bit first, one 16-bit word per clock in index order). It compares each clean result with the one from the scan before, so a stored bit that flips without a host write is caught. Any host write to a covered word is caught directly. Both events raise one sticky integrity flag. With its mask bit set, that flag pulls an active-low interrupt.

The host reaches the block through a parallel bus. A one-cycle request is answered by a one-cycle completion strobe with an ok bit and read data. The block also records the kind, address and data of the most recent successful transaction, so that software can check what the serial front end actually delivered.

Covered words are indexed in this order: 13 configuration words (index 0..12, host address 0x0100+i), 63 data-memory words (index 13..75, host address 0x4380..0x43BE), and 8 internal words (index 76..83, host address 0x0200+k, read-only to the host, reset value 0xA500+k). The scanner runs three states. SC_IDLE seeds the CRC and always moves to SC_WALK. SC_WALK folds one word per cycle and moves to SC_CHECK after the last word. SC_CHECK makes the comparison and always returns to SC_IDLE. One scan period is therefore 86 cycles.

Top module: `reg_integrity_monitor`

## Requirements
- R1: After reset, configuration and data-memory words read 0, internal word k reads 0xA500+k, the status, mask and all three capture registers read 0, and irq_n is 1.
- R2: Each request gets rsp_done high for exactly the following cycle. Reads succeed (rsp_ok=1) at covered, internal, status (0x0300), mask (0x0301) and capture (0x0310..0x0312) addresses. Writes succeed only at covered, status and mask addresses. Failed or write responses return rdata 0, and word reads are zero-extended.
- R3: A successful write to a configuration or data-memory word stores its low 16 bits and sets status bit 25, even when the value is unchanged.
- R4: A single-cycle fault pulse flips bit fault_bit of word fault_idx. When no covered write occurred during the preceding three scan periods, status bit 25 is set within two scan periods of the fault.
- R5: Status bit 25 is sticky. Writing the status register with bit 25 = 1 clears it, and writing with bit 25 = 0 leaves it. All other status bits read 0.
- R6: irq_n is 0 exactly while status bit 25 and mask bit 25 are both 1. Clearing either bit returns it to 1.
- R7: After a successful transaction outside the capture addresses, the capture registers hold the kind (0x35 read, 0xCA write) at 0x0310, the address at 0x0311, and the full write data or the returned read data at 0x0312.
- R8: Failed transactions and reads of the capture registers leave all three capture registers unchanged.
- R9: scan_busy is high for exactly 84 cycles in every 86-cycle scan period.
- R10: A write to an internal word fails, leaves the word unchanged and does not set status bit 25.
- R11: With no covered writes and no faults, status bit 25 is never set by the scanner. Writes to status or mask never set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle host request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Host word address |
| req_wdata | input | 32 | Write data |
| rsp_done | output | 1 | Completion strobe, one cycle after the request |
| rsp_ok | output | 1 | Transaction succeeded |
| rsp_rdata | output | 32 | Read data |
| irq_n | output | 1 | Active-low integrity interrupt |
| scan_busy | output | 1 | Checksum walk in progress |
| fault_en | input | 1 | One-cycle bit-flip injection |
| fault_idx | input | 7 | Word index for injection |
| fault_bit | input | 4 | Bit position for injection |

## Verification
A stale or corrupt CRC reference, or a scan that skips words, shows up at irq_n and at the status read. It appears either as a missed fault or as a false alarm, within two scan periods (172 cycles) of the event. A storage fault or a wrong address decode appears on the very next read of the word, in rsp_ok or rsp_rdata. A capture register that updates when it should not, or fails to update, appears on the next read of the capture addresses. A response strobe that is early, late or missing is visible in the cycle after the request.

// File: rtl/rim_pkg.sv
package rim_pkg;
    localparam int WORD_W   = 16;
    localparam int BUS_W    = 32;
    localparam int FLAG_BIT = 25;

    localparam logic [7:0]  KIND_READ  = 8'h35;
    localparam logic [7:0]  KIND_WRITE = 8'hCA;
    localparam logic [15:0] CRC_POLY   = 16'h1021;
    localparam logic [15:0] CRC_SEED   = 16'hFFFF;

    typedef enum logic [1:0] {
        SC_IDLE  = 2'd0,
        SC_WALK  = 2'd1,
        SC_CHECK = 2'd2
    } scan_state_t;

    // Fold one word into the CRC, most significant bit first.
    function automatic logic [15:0] crc_fold(input logic [15:0] crc_in,
                                             input logic [WORD_W-1:0] word);
        logic [15:0] c;
        c = crc_in;
        for (int b = WORD_W - 1; b >= 0; b--) begin
            if (c[15] ^ word[b]) c = {c[14:0], 1'b0} ^ CRC_POLY;
            else                 c = {c[14:0], 1'b0};
        end
        return c;
    endfunction
endpackage

// File: rtl/rim_store.sv
module rim_store
    import rim_pkg::*;
#(
    parameter int          NCFG     = 13,
    parameter int          NMEM     = 63,
    parameter int          NINT     = 8,
    parameter int          NW       = NCFG + NMEM + NINT,
    parameter int          IW       = $clog2(NW),
    parameter int          BW       = $clog2(WORD_W),
    parameter logic [15:0] INT_SEED = 16'hA500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IW-1:0]     wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              flt_en,
    input  logic [IW-1:0]     flt_idx,
    input  logic [BW-1:0]     flt_bit,
    input  logic [IW-1:0]     rd_idx,
    output logic [WORD_W-1:0] rd_data,
    input  logic [IW-1:0]     sc_idx,
    output logic [WORD_W-1:0] sc_data
);
    localparam int HOST_W = NCFG + NMEM;

    logic [WORD_W-1:0] word_q  [NW];
    logic [WORD_W-1:0] rst_val [NW];

    for (genvar g = 0; g < NW; g++) begin : g_rst
        if (g >= HOST_W) begin : g_int
            assign rst_val[g] = INT_SEED + WORD_W'(g - HOST_W);
        end else begin : g_cov
            assign rst_val[g] = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NW; i++) word_q[i] <= rst_val[i];
        end else begin
            for (int i = 0; i < NW; i++) begin
                if (flt_en && flt_idx == IW'(i))
                    word_q[i] <= word_q[i] ^ (WORD_W'(1) << flt_bit);
                else if (wr_en && wr_idx == IW'(i) && i < HOST_W)
                    word_q[i] <= wr_data;
            end
        end
    end

    assign rd_data = ({1'b0, rd_idx} < (IW + 1)'(NW)) ? word_q[rd_idx] : '0;
    assign sc_data = ({1'b0, sc_idx} < (IW + 1)'(NW)) ? word_q[sc_idx] : '0;
endmodule

// File: rtl/rim_scan.sv
module rim_scan
    import rim_pkg::*;
#(
    parameter int NW = 84,
    parameter int IW = $clog2(NW)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cov_write,
    output logic [IW-1:0]     sc_idx,
    input  logic [WORD_W-1:0] sc_data,
    output logic              busy,
    output logic              mismatch
);
    scan_state_t state_q, state_d;
    logic [IW-1:0] idx_q;
    logic [15:0]   crc_q, ref_q;
    logic          have_ref_q, taint_q;

    // next-state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SC_IDLE:  state_d = SC_WALK;
            SC_WALK:  if (idx_q == IW'(NW - 1)) state_d = SC_CHECK;
            SC_CHECK: state_d = SC_IDLE;
            default:  state_d = SC_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SC_IDLE;
        else        state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q      <= '0;
            crc_q      <= CRC_SEED;
            ref_q      <= '0;
            have_ref_q <= 1'b0;
            taint_q    <= 1'b0;
            mismatch   <= 1'b0;
        end else begin
            mismatch <= 1'b0;
            taint_q  <= (state_q == SC_CHECK) ? 1'b0 : (taint_q | cov_write);
            unique case (state_q)
                SC_IDLE: begin
                    idx_q <= '0;
                    crc_q <= CRC_SEED;
                end
                SC_WALK: begin
                    crc_q <= crc_fold(crc_q, sc_data);
                    if (idx_q != IW'(NW - 1)) idx_q <= idx_q + 1'b1;
                end
                SC_CHECK: begin
                    if (taint_q || cov_write) begin
                        have_ref_q <= 1'b0;
                    end else if (!have_ref_q) begin
                        ref_q      <= crc_q;
                        have_ref_q <= 1'b1;
                    end else begin
                        mismatch <= (crc_q != ref_q);
                        ref_q    <= crc_q;
                    end
                end
                default: ;
            endcase
        end
    end

    assign sc_idx = idx_q;
    assign busy   = (state_q == SC_WALK);
endmodule

// File: rtl/rim_access.sv
module rim_access
    import rim_pkg::*;
#(
    parameter int          NCFG      = 13,
    parameter int          NMEM      = 63,
    parameter int          NW        = 84,
    parameter int          IW        = $clog2(NW),
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] CFG_BASE  = 16'h0100,
    parameter logic [15:0] MEM_BASE  = 16'h4380,
    parameter logic [15:0] INT_BASE  = 16'h0200,
    parameter logic [15:0] STAT_ADDR = 16'h0300,
    parameter logic [15:0] MASK_ADDR = 16'h0301,
    parameter logic [15:0] CAP_BASE  = 16'h0310
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BUS_W-1:0]  req_wdata,
    input  logic [WORD_W-1:0] rd_data,
    input  logic              mismatch,
    output logic              wr_en,
    output logic [IW-1:0]     acc_idx,
    output logic              rsp_done,
    output logic              rsp_ok,
    output logic [BUS_W-1:0]  rsp_rdata,
    output logic              flag_q,
    output logic [ADDR_W-1:0] cap_addr,
    output logic              irq_n
);
    localparam int NINT = NW - NCFG - NMEM;

    logic [ADDR_W-1:0] o_cfg, o_mem, o_int, o_cap;
    logic hit_cfg, hit_mem, hit_int, hit_stat, hit_mask, hit_cap, hit_cov, ok;
    logic [BUS_W-1:0] rdata_c;
    logic             mask_q;
    logic [7:0]       cap_kind;
    logic [BUS_W-1:0] cap_data;

    assign o_cfg    = req_addr - ADDR_W'(CFG_BASE);
    assign o_mem    = req_addr - ADDR_W'(MEM_BASE);
    assign o_int    = req_addr - ADDR_W'(INT_BASE);
    assign o_cap    = req_addr - ADDR_W'(CAP_BASE);
    assign hit_cfg  = o_cfg < ADDR_W'(NCFG);
    assign hit_mem  = o_mem < ADDR_W'(NMEM);
    assign hit_int  = o_int < ADDR_W'(NINT);
    assign hit_cap  = o_cap < ADDR_W'(3);
    assign hit_stat = req_addr == ADDR_W'(STAT_ADDR);
    assign hit_mask = req_addr == ADDR_W'(MASK_ADDR);
    assign hit_cov  = hit_cfg | hit_mem;

    always_comb begin
        if (hit_cfg)      acc_idx = o_cfg[IW-1:0];
        else if (hit_mem) acc_idx = IW'(NCFG) + o_mem[IW-1:0];
        else              acc_idx = IW'(NCFG + NMEM) + o_int[IW-1:0];
    end

    assign ok = req_write ? (hit_cov | hit_stat | hit_mask)
                          : (hit_cov | hit_int | hit_stat | hit_mask | hit_cap);

    always_comb begin
        rdata_c = '0;
        if (hit_cov || hit_int)   rdata_c = BUS_W'(rd_data);
        else if (hit_stat)        rdata_c = BUS_W'(flag_q) << FLAG_BIT;
        else if (hit_mask)        rdata_c = BUS_W'(mask_q) << FLAG_BIT;
        else if (hit_cap) begin
            unique case (o_cap[1:0])
                2'd0:    rdata_c = BUS_W'(cap_kind);
                2'd1:    rdata_c = BUS_W'(cap_addr);
                default: rdata_c = cap_data;
            endcase
        end
    end

    assign wr_en = req_valid & req_write & hit_cov;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_done  <= 1'b0;
            rsp_ok    <= 1'b0;
            rsp_rdata <= '0;
            flag_q    <= 1'b0;
            mask_q    <= 1'b0;
            cap_kind  <= '0;
            cap_addr  <= '0;
            cap_data  <= '0;
        end else begin
            rsp_done  <= req_valid;
            rsp_ok    <= req_valid & ok;
            rsp_rdata <= (req_valid && !req_write && ok) ? rdata_c : '0;
            if (wr_en || mismatch)
                flag_q <= 1'b1;
            else if (req_valid && req_write && hit_stat && req_wdata[FLAG_BIT])
                flag_q <= 1'b0;
            if (req_valid && req_write && hit_mask)
                mask_q <= req_wdata[FLAG_BIT];
            if (req_valid && ok && !hit_cap) begin
                cap_kind <= req_write ? KIND_WRITE : KIND_READ;
                cap_addr <= req_addr;
                cap_data <= req_write ? req_wdata : rdata_c;
            end
        end
    end

    assign irq_n = ~(flag_q & mask_q);
endmodule

// File: rtl/reg_integrity_monitor.sv
module reg_integrity_monitor
    import rim_pkg::*;
#(
    parameter int          NCFG      = 13,
    parameter int          NMEM      = 63,
    parameter int          NINT      = 8,
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] CFG_BASE  = 16'h0100,
    parameter logic [15:0] MEM_BASE  = 16'h4380,
    parameter logic [15:0] INT_BASE  = 16'h0200,
    parameter logic [15:0] STAT_ADDR = 16'h0300,
    parameter logic [15:0] MASK_ADDR = 16'h0301,
    parameter logic [15:0] CAP_BASE  = 16'h0310,
    parameter logic [15:0] INT_SEED  = 16'hA500,
    localparam int         NW        = NCFG + NMEM + NINT,
    localparam int         IW        = $clog2(NW),
    localparam int         BW        = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BUS_W-1:0]  req_wdata,
    output logic              rsp_done,
    output logic              rsp_ok,
    output logic [BUS_W-1:0]  rsp_rdata,
    output logic              irq_n,
    output logic              scan_busy,
    input  logic              fault_en,
    input  logic [IW-1:0]     fault_idx,
    input  logic [BW-1:0]     fault_bit
);
    logic              cov_write, mismatch, flag_q;
    logic [IW-1:0]     acc_idx, sc_idx;
    logic [WORD_W-1:0] rd_data, sc_data;
    logic [ADDR_W-1:0] cap_addr;

    rim_store #(
        .NCFG(NCFG), .NMEM(NMEM), .NINT(NINT), .NW(NW), .IW(IW), .BW(BW),
        .INT_SEED(INT_SEED)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cov_write), .wr_idx(acc_idx), .wr_data(req_wdata[WORD_W-1:0]),
        .flt_en(fault_en), .flt_idx(fault_idx), .flt_bit(fault_bit),
        .rd_idx(acc_idx), .rd_data(rd_data),
        .sc_idx(sc_idx), .sc_data(sc_data)
    );

    rim_scan #(.NW(NW), .IW(IW)) u_scan (
        .clk(clk), .rst_n(rst_n), .cov_write(cov_write),
        .sc_idx(sc_idx), .sc_data(sc_data),
        .busy(scan_busy), .mismatch(mismatch)
    );

    rim_access #(
        .NCFG(NCFG), .NMEM(NMEM), .NW(NW), .IW(IW), .ADDR_W(ADDR_W),
        .CFG_BASE(CFG_BASE), .MEM_BASE(MEM_BASE), .INT_BASE(INT_BASE),
        .STAT_ADDR(STAT_ADDR), .MASK_ADDR(MASK_ADDR), .CAP_BASE(CAP_BASE)
    ) u_access (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_data(rd_data), .mismatch(mismatch),
        .wr_en(cov_write), .acc_idx(acc_idx),
        .rsp_done(rsp_done), .rsp_ok(rsp_ok), .rsp_rdata(rsp_rdata),
        .flag_q(flag_q), .cap_addr(cap_addr), .irq_n(irq_n)
    );
endmodule

// File: rtl/rim_checker.sv
module rim_checker #(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] STAT_ADDR = 16'h0300
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic              clr_bit,
    input logic              rsp_done,
    input logic              rsp_ok,
    input logic              cov_write,
    input logic              mismatch,
    input logic              flag_q,
    input logic [ADDR_W-1:0] cap_addr
);
    logic clr_req;
    assign clr_req = req_valid && req_write && req_addr == ADDR_W'(STAT_ADDR) && clr_bit;

    AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_done);  // R2
    AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_done);  // R2
    AST_WRITE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        cov_write |=> flag_q);  // R3
    AST_MISMATCH_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch |=> flag_q);  // R4
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_req) |=> flag_q);  // R5
    AST_FAIL_KEEPS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && !rsp_ok) |-> $stable(cap_addr));  // R8
endmodule

bind reg_integrity_monitor rim_checker #(.ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR)) u_rim_checker (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .clr_bit(req_wdata[rim_pkg::FLAG_BIT]),
    .rsp_done(rsp_done), .rsp_ok(rsp_ok),
    .cov_write(cov_write), .mismatch(mismatch),
    .flag_q(flag_q), .cap_addr(cap_addr)
);

// File: tb/reg_integrity_monitor_bench.sv
`timescale 1ns/1ps
module reg_integrity_monitor_bench;
    localparam int NCFG = 13, NMEM = 63, NINT = 8;
    localparam int NW = NCFG + NMEM + NINT;
    localparam int P  = NW + 2;
    localparam logic [15:0] A_CFG = 16'h0100, A_MEM = 16'h4380, A_INT = 16'h0200;
    localparam logic [15:0] A_STAT = 16'h0300, A_MASK = 16'h0301, A_CAP = 16'h0310;
    localparam logic [31:0] BIT25 = 32'h0200_0000;

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, req_write = 0;
    logic [15:0] req_addr = 0;
    logic [31:0] req_wdata = 0;
    logic rsp_done, rsp_ok, irq_n, scan_busy;
    logic [31:0] rsp_rdata;
    logic fault_en = 0;
    logic [6:0] fault_idx = 0;
    logic [3:0] fault_bit = 0;

    always #2.5 clk = ~clk;

    reg_integrity_monitor u_reg_integrity_monitor (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_done(rsp_done),
        .rsp_ok(rsp_ok), .rsp_rdata(rsp_rdata), .irq_n(irq_n),
        .scan_busy(scan_busy), .fault_en(fault_en), .fault_idx(fault_idx),
        .fault_bit(fault_bit)
    );

    int n_chk = 0, n_err = 0;
    logic [15:0] mdl [NW];
    bit flag_m = 0, mask_m = 0;
    logic [31:0] cap_k = 0, cap_a = 0, cap_d = 0;

    task automatic chk(input bit cond, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!cond) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // address kinds: 0 none,1 cfg,2 mem,3 internal,4 status,5 mask,6..8 capture
    function automatic void classify(input logic [15:0] a, output int k, output int ix);
        k = 0; ix = 0;
        if (a >= A_CFG && a < A_CFG + NCFG)      begin k = 1; ix = int'(a - A_CFG); end
        else if (a >= A_MEM && a < A_MEM + NMEM) begin k = 2; ix = NCFG + int'(a - A_MEM); end
        else if (a >= A_INT && a < A_INT + NINT) begin k = 3; ix = NCFG + NMEM + int'(a - A_INT); end
        else if (a == A_STAT) k = 4;
        else if (a == A_MASK) k = 5;
        else if (a >= A_CAP && a < A_CAP + 3)    k = 6 + int'(a - A_CAP);
    endfunction

    task automatic txn(input bit w, input logic [15:0] a, input logic [31:0] d, input string tag);
        int k, ix;
        bit ok_e;
        logic [31:0] rd_e;
        classify(a, k, ix);
        ok_e = w ? (k == 1 || k == 2 || k == 4 || k == 5) : (k != 0);
        rd_e = 0;
        if (!w && ok_e) begin
            case (k)
                1, 2, 3: rd_e = {16'h0, mdl[ix]};
                4:       rd_e = flag_m ? BIT25 : 0;
                5:       rd_e = mask_m ? BIT25 : 0;
                6:       rd_e = cap_k;
                7:       rd_e = cap_a;
                default: rd_e = cap_d;
            endcase
        end
        @(negedge clk);
        req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 0;
        chk(rsp_done === 1'b1 && rsp_ok === ok_e && rsp_rdata === rd_e, tag,
            {rsp_done, 7'h0, rsp_ok, 23'h0, rsp_rdata}, {8'h1, 7'h0, ok_e, 23'h0, rd_e});
        if (w && ok_e) begin
            if (k == 1 || k == 2) begin mdl[ix] = d[15:0]; flag_m = 1; end
            if (k == 4 && d[25]) flag_m = 0;
            if (k == 5) mask_m = d[25];
        end
        if (ok_e && k < 6) begin
            cap_k = w ? 32'hCA : 32'h35;
            cap_a = {16'h0, a};
            cap_d = w ? d : rd_e;
        end
        chk(irq_n === ~(flag_m & mask_m), {tag, " R6 irq"}, {63'h0, irq_n}, {63'h0, ~(flag_m & mask_m)});
    endtask

    task automatic inject(input int ix, input int b);
        @(negedge clk);
        fault_en = 1; fault_idx = 7'(ix); fault_bit = 4'(b);
        @(negedge clk);
        fault_en = 0;
        mdl[ix] = mdl[ix] ^ (16'h1 << b);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : main
        int busy_cnt;
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < NW; i++) mdl[i] = (i >= NCFG + NMEM) ? 16'hA500 + 16'(i - NCFG - NMEM) : 16'h0;
        idle(3);
        rst_n = 1;
        idle(2);

        // R1 reset state: capture first so nothing overwrites it
        chk(irq_n === 1'b1 && rsp_done === 1'b0, "R1 irq/rsp after reset", {62'h0, irq_n, rsp_done}, 64'h2);
        txn(0, A_CAP,     0, "R1 capture kind");
        txn(0, A_CAP + 1, 0, "R1 capture addr");
        txn(0, A_CAP + 2, 0, "R1 capture data");
        txn(0, A_STAT, 0, "R1 status");
        txn(0, A_MASK, 0, "R1 mask");
        txn(0, A_CFG, 0, "R1 cfg word 0");
        txn(0, A_MEM + NMEM - 1, 0, "R1 last mem word");
        txn(0, A_INT, 0, "R1 internal 0");
        txn(0, A_INT + NINT - 1, 0, "R1 internal 7");

        // R2 unmapped and strobe length
        txn(0, 16'h5000, 0, "R2 unmapped read");
        txn(1, A_CAP, 32'h55, "R2 write to capture fails");
        @(negedge clk);
        chk(rsp_done === 1'b0, "R2 strobe one cycle", {63'h0, rsp_done}, 64'h0);

        // R9 busy duty over one period
        busy_cnt = 0;
        for (int i = 0; i < P; i++) begin
            @(negedge clk);
            if (scan_busy) busy_cnt++;
        end
        chk(busy_cnt == NW, "R9 busy cycles per period", 64'(busy_cnt), 64'(NW));

        // R3 same-value write sets flag; R6 masked off keeps irq high
        txn(1, A_MEM, 32'h0, "R3 write same value");
        txn(0, A_STAT, 0, "R3 status after write");
        // R5 write with bit clear keeps flag; R6 mask raises irq
        txn(1, A_STAT, 32'h0, "R5 write zero keeps");
        txn(0, A_STAT, 0, "R5 status still set");
        txn(1, A_MASK, BIT25, "R6 set mask");
        txn(1, A_MASK, 32'h0, "R6 clear mask releases");
        txn(1, A_MASK, BIT25, "R6 set mask again");
        txn(1, A_STAT, BIT25, "R5 clear flag releases irq");
        txn(0, A_STAT, 0, "R5 status cleared");

        // R7 capture of write and read
        txn(1, A_CFG + 3, 32'h1234ABCD, "R7 write cfg");
        txn(0, A_CAP,     0, "R7 kind write");
        txn(0, A_CAP + 1, 0, "R7 addr write");
        txn(0, A_CAP + 2, 0, "R7 data write");
        txn(0, A_CFG + 3, 0, "R3 truncated store");
        txn(0, A_CAP + 2, 0, "R7 data read");
        txn(0, A_CAP,     0, "R8 capture read does not update");

        // R10 internal not writable, R8 failure keeps capture
        txn(1, A_STAT, BIT25, "R10 clear before");
        txn(1, A_INT + 2, 32'hFFFF, "R10 internal write fails");
        txn(0, A_CAP + 1, 0, "R8 capture after failure");
        txn(0, A_INT + 2, 0, "R10 internal unchanged");
        txn(0, A_STAT, 0, "R10 no flag");

        // random mix
        for (int n = 0; n < 160; n++) begin
            int r;
            logic [15:0] a;
            r = $urandom_range(0, 9);
            if (r < 4)      a = A_CFG + 16'($urandom_range(0, NCFG - 1));
            else if (r < 8) a = A_MEM + 16'($urandom_range(0, NMEM - 1));
            else if (r < 9) a = A_INT + 16'($urandom_range(0, NINT - 1));
            else            a = 16'h6000 + 16'($urandom_range(0, 255));
            txn(1'($urandom_range(0, 1)), a, $urandom, "R2 R3 R7 random");
        end
        txn(0, A_CAP,     0, "R7 random kind");
        txn(0, A_CAP + 1, 0, "R7 random addr");
        txn(0, A_CAP + 2, 0, "R7 random data");
        txn(0, A_STAT, 0, "R3 random status");
        txn(1, A_STAT, BIT25, "R5 clear after random");

        // R4 fault in data memory
        idle(3 * P + 5);
        inject(NCFG + 5, 3);
        idle(2 * P + 5);
        flag_m = 1;
        txn(0, A_STAT, 0, "R4 mem fault flagged");
        txn(0, A_MEM + 5, 0, "R4 mem bit flipped");
        txn(1, A_STAT, BIT25, "R5 clear after fault");

        // R4 fault in internal word
        idle(3 * P + 5);
        inject(NCFG + NMEM + 2, 15);
        idle(2 * P + 5);
        flag_m = 1;
        txn(0, A_STAT, 0, "R4 internal fault flagged");
        txn(0, A_INT + 2, 0, "R4 internal bit flipped");
        txn(1, A_STAT, BIT25, "R5 clear again");

        // R11 quiet scans and status/mask writes raise nothing
        txn(1, A_MASK, BIT25, "R11 mask write");
        idle(4 * P);
        txn(0, A_STAT, 0, "R11 no false alarm");
        chk(irq_n === 1'b1, "R11 irq stays high", {63'h0, irq_n}, 64'h1);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule